// File: doc/BRIEF.md
# Multi-Mode Operand Locator

This block sits in front of a load/store unit and turns an operand specifier into the thing the datapath needs: a plain operand value, a byte address for memory, or, for the pointer-chasing mode, an address obtained by first reading a pointer from memory. The request carries a mode code, the contents of a base register and an index register, a literal field taken from the instruction, an index scale code and an access size. The result comes back tagged with a kind so the consumer knows whether to use the value directly or to issue a memory access with it.

The two auto-modifying modes also return an updated base value together with a single-cycle writeback strobe, which the register file uses to update the base register. The pointer-chasing mode runs a short sequence over a synchronous read port with a valid/ready handshake. During that sequence the block reports busy and refuses new requests. Every other mode answers exactly one cycle after the request is taken.

Top module: `opnd_locator`

## Requirements
- R1: After reset `res_valid`, `wb_en`, `busy` and `mem_rd_valid` are low and `req_ready` is high.
- R2: Mode 0 (register) returns `base_val` and mode 1 (immediate) returns `literal`. Both use result kind 0 (value) and issue no memory read. The result appears with `res_valid` in the cycle after the request is accepted.
- R3: Mode 2 (absolute) returns `literal` and mode 4 (register indirect) returns `base_val`. Both use result kind 1 (address).
- R4: Mode 3 (displacement) returns `base_val + literal` and mode 5 (indexed) returns `base_val + index_val`. Both use kind 1.
- R5: Mode 6 (scaled index) returns `base_val + (index_val << req_scale) + literal` with kind 1. Scale codes 0 to 3 multiply the index by 1, 2, 4 or 8.
- R6: Mode 7 (post-increment) returns `base_val` as the address with kind 1. In the same cycle it raises `wb_en` with `wb_value = base_val + step`. The step is set by `req_size`: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R7: Mode 8 (pre-decrement) returns `base_val - step` as the address with kind 1, raises `wb_en`, and sets `wb_value` equal to that same address.
- R8: Mode 9 (memory indirect) drives `mem_rd_valid` with `mem_rd_addr = base_val` in the cycle after acceptance. The read data must be presented in the cycle after the read handshake. The captured word is returned with kind 1 in the following cycle. With no stall, the result arrives three cycles after acceptance, and `busy` is high during the two cycles in between.
- R9: While `busy` is high, `req_ready` is low and requests are ignored. An ignored request produces no result and no memory read.
- R10: While `mem_rd_valid` is high and `mem_rd_ready` is low, `mem_rd_valid` stays high and `mem_rd_addr` holds its value.
- R11: All address arithmetic wraps modulo 2^32, with no flag raised.
- R12: Mode codes 10 to 15 return a result of kind 2 (none) with value 0 and no writeback.
- R13: `wb_en` is high only together with a result from mode 7 or mode 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 4 | Addressing mode code |
| req_size | input | 2 | Access size code (1, 2, 4 bytes) |
| req_scale | input | 2 | Index shift amount |
| base_val | input | 32 | Base register contents |
| index_val | input | 32 | Index register contents |
| literal | input | 32 | Literal field of the instruction |
| res_valid | output | 1 | Result strobe |
| res_kind | output | 2 | 0 value, 1 address, 2 none |
| res_value | output | 32 | Operand value or address |
| wb_en | output | 1 | Base register writeback strobe |
| wb_value | output | 32 | Updated base value |
| busy | output | 1 | Indirect sequence in progress |
| mem_rd_valid | output | 1 | Pointer read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Pointer read address |
| mem_rd_data | input | 32 | Pointer word, one cycle after the handshake |

## Verification
The hardest situation to reach is a new request arriving while an indirect sequence is stalled on the memory port. The address must stay frozen, and the request must leave no trace in either the result or the read port. The stimulus starts a mode-9 access, then holds `mem_rd_ready` low for several cycles while it keeps `req_valid` high with a different mode. It then completes the read and confirms that exactly one result appears, that this result carries the pointer word, and that no second read starts.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

   typedef enum logic [3:0] {
      MD_REG   = 4'd0,
      MD_IMM   = 4'd1,
      MD_ABS   = 4'd2,
      MD_DISP  = 4'd3,
      MD_RIND  = 4'd4,
      MD_IDX   = 4'd5,
      MD_SCL   = 4'd6,
      MD_PINC  = 4'd7,
      MD_PDEC  = 4'd8,
      MD_MIND  = 4'd9
   } mode_e;

   typedef enum logic [1:0] {
      RK_VALUE = 2'd0,
      RK_ADDR  = 2'd1,
      RK_NONE  = 2'd2
   } kind_e;

   localparam int MODE_W = 4;
   localparam int KIND_W = 2;
   localparam int SIZE_W = 2;

endpackage

// File: rtl/opnd_addr_calc.sv
module opnd_addr_calc
   import opnd_pkg::*;
#(
   parameter int AW      = 32,
   parameter int SCALE_W = 2
) (
   input  logic [MODE_W-1:0]  mode,
   input  logic [SIZE_W-1:0]  size,
   input  logic [SCALE_W-1:0] scale,
   input  logic [AW-1:0]      base,
   input  logic [AW-1:0]      index,
   input  logic [AW-1:0]      lit,
   output logic [KIND_W-1:0]  kind,
   output logic [AW-1:0]      value,
   output logic               wb_req,
   output logic [AW-1:0]      wb_data,
   output logic               indirect
);

   localparam int NSHIFT = 1 << SCALE_W;

   logic [AW-1:0] shifted [NSHIFT];
   logic [AW-1:0] step;
   logic [AW-1:0] scaled;

   generate
      for (genvar s = 0; s < NSHIFT; s++) begin : g_shift
         assign shifted[s] = index << s;
      end
   endgenerate

   assign scaled = shifted[scale];

   always_comb begin
      case (size)
         2'd0:    step = AW'(1);
         2'd1:    step = AW'(2);
         default: step = AW'(4);
      endcase
   end

   always_comb begin
      kind     = RK_NONE;
      value    = '0;
      wb_req   = 1'b0;
      wb_data  = '0;
      indirect = 1'b0;
      case (mode_e'(mode))
         MD_REG:  begin kind = RK_VALUE; value = base; end
         MD_IMM:  begin kind = RK_VALUE; value = lit;  end
         MD_ABS:  begin kind = RK_ADDR;  value = lit;  end
         MD_DISP: begin kind = RK_ADDR;  value = base + lit; end
         MD_RIND: begin kind = RK_ADDR;  value = base; end
         MD_IDX:  begin kind = RK_ADDR;  value = base + index; end
         MD_SCL:  begin kind = RK_ADDR;  value = base + scaled + lit; end
         MD_PINC: begin
            kind    = RK_ADDR;
            value   = base;
            wb_req  = 1'b1;
            wb_data = base + step;
         end
         MD_PDEC: begin
            kind    = RK_ADDR;
            value   = base - step;
            wb_req  = 1'b1;
            wb_data = base - step;
         end
         MD_MIND: begin
            kind     = RK_ADDR;
            value    = base;
            indirect = 1'b1;
         end
         default: begin
            kind  = RK_NONE;
            value = '0;
         end
      endcase
   end

endmodule

// File: rtl/opnd_indirect_fsm.sv
module opnd_indirect_fsm #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] ptr_addr,
   output logic          busy,
   output logic          mem_rd_valid,
   input  logic          mem_rd_ready,
   output logic [AW-1:0] mem_rd_addr,
   input  logic [AW-1:0] mem_rd_data,
   output logic          done,
   output logic [AW-1:0] final_addr
);

   typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WAIT} ind_state_e;

   ind_state_e    state_q;
   logic [AW-1:0] addr_q;
   logic          done_q;
   logic [AW-1:0] final_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         done_q  <= 1'b0;
         final_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_READ;
               addr_q  <= ptr_addr;
            end
            ST_READ: if (mem_rd_ready) state_q <= ST_WAIT;
            ST_WAIT: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
               final_q <= mem_rd_data;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy         = (state_q != ST_IDLE);
   assign mem_rd_valid = (state_q == ST_READ);
   assign mem_rd_addr  = addr_q;
   assign done         = done_q;
   assign final_addr   = final_q;

   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   // R8
   rd_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mem_rd_valid && busy));

   // R8
   done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_rd_valid) |=> (done && !busy));

endmodule

// File: rtl/opnd_locator.sv
module opnd_locator
   import opnd_pkg::*;
#(
   parameter int AW      = 32,
   parameter int SCALE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [3:0]         req_mode,
   input  logic [1:0]         req_size,
   input  logic [SCALE_W-1:0] req_scale,
   input  logic [AW-1:0]      base_val,
   input  logic [AW-1:0]      index_val,
   input  logic [AW-1:0]      literal,
   output logic               res_valid,
   output logic [1:0]         res_kind,
   output logic [AW-1:0]      res_value,
   output logic               wb_en,
   output logic [AW-1:0]      wb_value,
   output logic               busy,
   output logic               mem_rd_valid,
   input  logic               mem_rd_ready,
   output logic [AW-1:0]      mem_rd_addr,
   input  logic [AW-1:0]      mem_rd_data
);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("opnd_locator: AW must be at least 8");
      end
      if (SCALE_W < 1 || SCALE_W > 3) begin : g_bad_scale
         $error("opnd_locator: SCALE_W must be 1..3");
      end
   endgenerate

   logic              accept;
   logic [KIND_W-1:0] c_kind;
   logic [AW-1:0]     c_value;
   logic              c_wb;
   logic [AW-1:0]     c_wb_data;
   logic              c_ind;
   logic              ind_busy;
   logic              ind_done;
   logic [AW-1:0]     ind_addr;

   logic              dir_valid_q;
   logic [KIND_W-1:0] dir_kind_q;
   logic [AW-1:0]     dir_value_q;
   logic              dir_wb_q;
   logic [AW-1:0]     dir_wb_data_q;

   assign req_ready = !ind_busy;
   assign accept    = req_valid && req_ready;

   opnd_addr_calc #(.AW(AW), .SCALE_W(SCALE_W)) u_calc (
      .mode     (req_mode),
      .size     (req_size),
      .scale    (req_scale),
      .base     (base_val),
      .index    (index_val),
      .lit      (literal),
      .kind     (c_kind),
      .value    (c_value),
      .wb_req   (c_wb),
      .wb_data  (c_wb_data),
      .indirect (c_ind)
   );

   opnd_indirect_fsm #(.AW(AW)) u_ind (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (accept && c_ind),
      .ptr_addr     (c_value),
      .busy         (ind_busy),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_ready (mem_rd_ready),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_data  (mem_rd_data),
      .done         (ind_done),
      .final_addr   (ind_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_valid_q   <= 1'b0;
         dir_kind_q    <= RK_NONE;
         dir_value_q   <= '0;
         dir_wb_q      <= 1'b0;
         dir_wb_data_q <= '0;
      end else begin
         dir_valid_q <= accept && !c_ind;
         dir_wb_q    <= accept && !c_ind && c_wb;
         if (accept && !c_ind) begin
            dir_kind_q    <= c_kind;
            dir_value_q   <= c_value;
            dir_wb_data_q <= c_wb_data;
         end
      end
   end

   assign res_valid = dir_valid_q || ind_done;
   assign res_kind  = ind_done ? RK_ADDR  : dir_kind_q;
   assign res_value = ind_done ? ind_addr : dir_value_q;
   assign wb_en     = dir_wb_q;
   assign wb_value  = dir_wb_data_q;
   assign busy      = ind_busy;

   // R13
   wb_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (res_valid && res_kind == RK_ADDR));

   // R9
   ready_vs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);

   // R9
   no_result_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> !res_valid);

   // R2
   direct_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_mode != 4'd9) |=> res_valid);

   // R12
   none_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind == RK_NONE) |-> (res_value == '0 && !wb_en));

endmodule

// File: tb/sim_opnd_locator.sv
module sim_opnd_locator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_mode = '0;
   logic [1:0]  req_size = '0;
   logic [1:0]  req_scale = '0;
   logic [31:0] base_val = '0;
   logic [31:0] index_val = '0;
   logic [31:0] literal = '0;
   logic        res_valid;
   logic [1:0]  res_kind;
   logic [31:0] res_value;
   logic        wb_en;
   logic [31:0] wb_value;
   logic        busy;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_addr;
   logic [31:0] mem_rd_data = '0;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   opnd_locator u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_size(req_size), .req_scale(req_scale),
      .base_val(base_val), .index_val(index_val), .literal(literal),
      .res_valid(res_valid), .res_kind(res_kind), .res_value(res_value),
      .wb_en(wb_en), .wb_value(wb_value), .busy(busy),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // issue one request, return at the negedge after the accepting edge
   task automatic issue(input logic [3:0] m, input logic [1:0] sz, input logic [1:0] sc,
                        input logic [31:0] b, input logic [31:0] x, input logic [31:0] l);
      req_mode = m; req_size = sz; req_scale = sc;
      base_val = b; index_val = x; literal = l;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_res(input string req, input logic [1:0] k, input logic [31:0] v,
                             input logic w, input logic [31:0] wv);
      chk({req, " res_valid"}, 32'(res_valid), 32'd1);
      chk({req, " kind"}, 32'(res_kind), 32'(k));
      chk({req, " value"}, res_value, v);
      chk({req, " wb_en"}, 32'(wb_en), 32'(w));
      if (w) chk({req, " wb_value"}, wb_value, wv);
      chk({req, " no mem read"}, 32'(mem_rd_valid), 32'd0);
   endtask

   task automatic t_reset();
      chk("R1 res_valid", 32'(res_valid), 0);
      chk("R1 wb_en", 32'(wb_en), 0);
      chk("R1 busy", 32'(busy), 0);
      chk("R1 mem_rd_valid", 32'(mem_rd_valid), 0);
      chk("R1 req_ready", 32'(req_ready), 1);
   endtask

   task automatic t_value_modes();
      issue(4'd0, 2'd0, 2'd0, 32'h1234_5678, 32'h9, 32'hDEAD_BEEF);
      expect_res("R2 reg", 2'd0, 32'h1234_5678, 1'b0, 0);
      issue(4'd1, 2'd0, 2'd0, 32'h1234_5678, 32'h9, 32'hDEAD_BEEF);
      expect_res("R2 imm", 2'd0, 32'hDEAD_BEEF, 1'b0, 0);
      @(posedge clk); @(negedge clk);
      chk("R2 single pulse", 32'(res_valid), 0);
   endtask

   task automatic t_plain_addr();
      issue(4'd2, 2'd0, 2'd0, 32'h1000, 32'h4, 32'h0000_8000);
      expect_res("R3 abs", 2'd1, 32'h0000_8000, 1'b0, 0);
      issue(4'd4, 2'd0, 2'd0, 32'h0000_1000, 32'h4, 32'h8000);
      expect_res("R3 rind", 2'd1, 32'h0000_1000, 1'b0, 0);
      issue(4'd3, 2'd0, 2'd0, 32'h0000_1000, 32'h4, 32'h0000_0024);
      expect_res("R4 disp", 2'd1, 32'h0000_1024, 1'b0, 0);
      issue(4'd5, 2'd0, 2'd0, 32'h0000_1000, 32'h0000_0300, 32'h24);
      expect_res("R4 idx", 2'd1, 32'h0000_1300, 1'b0, 0);
   endtask

   task automatic t_scaled();
      for (int s = 0; s < 4; s++) begin
         issue(4'd6, 2'd0, 2'(s), 32'h0000_2000, 32'h0000_0013, 32'h0000_0005);
         expect_res("R5 scaled", 2'd1, 32'h2005 + (32'h13 << s), 1'b0, 0);
      end
   endtask

   task automatic t_auto();
      issue(4'd7, 2'd0, 2'd0, 32'h0000_0100, 0, 0);
      expect_res("R6 inc size0", 2'd1, 32'h100, 1'b1, 32'h101);
      issue(4'd7, 2'd1, 2'd0, 32'h0000_0100, 0, 0);
      expect_res("R6 inc size1", 2'd1, 32'h100, 1'b1, 32'h102);
      issue(4'd7, 2'd3, 2'd0, 32'h0000_0100, 0, 0);
      expect_res("R6 inc size3", 2'd1, 32'h100, 1'b1, 32'h104);
      issue(4'd8, 2'd2, 2'd0, 32'h0000_0100, 0, 0);
      expect_res("R7 dec size2", 2'd1, 32'hFC, 1'b1, 32'hFC);
      issue(4'd8, 2'd1, 2'd0, 32'h0000_0100, 0, 0);
      expect_res("R7 dec size1", 2'd1, 32'hFE, 1'b1, 32'hFE);
      @(posedge clk); @(negedge clk);
      chk("R13 wb_en drops", 32'(wb_en), 0);
   endtask

   task automatic t_wrap();
      issue(4'd3, 2'd0, 2'd0, 32'hFFFF_FFF0, 0, 32'h0000_0020);
      expect_res("R11 disp wrap", 2'd1, 32'h0000_0010, 1'b0, 0);
      issue(4'd8, 2'd2, 2'd0, 32'h0000_0000, 0, 0);
      expect_res("R11 dec wrap", 2'd1, 32'hFFFF_FFFC, 1'b1, 32'hFFFF_FFFC);
      issue(4'd7, 2'd2, 2'd0, 32'hFFFF_FFFE, 0, 0);
      expect_res("R11 inc wrap", 2'd1, 32'hFFFF_FFFE, 1'b1, 32'h0000_0002);
      issue(4'd6, 2'd0, 2'd3, 32'h8000_0000, 32'h2000_0000, 32'h1);
      expect_res("R11 scaled wrap", 2'd1, 32'h8000_0001, 1'b0, 0);
   endtask

   task automatic t_illegal();
      for (int m = 10; m < 16; m++) begin
         issue(4'(m), 2'd0, 2'd0, 32'h55, 32'h66, 32'h77);
         expect_res("R12 illegal", 2'd2, 32'h0, 1'b0, 0);
      end
   endtask

   // pointer read with 'stall' cycles of ready low, competing request held on
   task automatic t_indirect(input int stall, input logic [31:0] ptr, input logic [31:0] word);
      req_mode = 4'd9; base_val = ptr; index_val = 0; literal = 0;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_mode = 4'd1; literal = 32'hBAD0_0000;   // competing request, kept valid
      chk("R8 read issued", 32'(mem_rd_valid), 1);
      chk("R8 read addr", mem_rd_addr, ptr);
      chk("R8 busy first", 32'(busy), 1);
      chk("R9 not ready", 32'(req_ready), 0);
      chk("R8 no early result", 32'(res_valid), 0);
      for (int i = 0; i < stall; i++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R10 valid held", 32'(mem_rd_valid), 1);
         chk("R10 addr held", mem_rd_addr, ptr);
         chk("R9 no result", 32'(res_valid), 0);
      end
      mem_rd_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_rd_ready = 1'b0;
      mem_rd_data  = word;
      chk("R8 read done", 32'(mem_rd_valid), 0);
      chk("R8 busy second", 32'(busy), 1);
      chk("R9 no result", 32'(res_valid), 0);
      @(posedge clk);
      @(negedge clk);
      req_valid   = 1'b0;
      mem_rd_data = 32'h0;
      chk("R8 result valid", 32'(res_valid), 1);
      chk("R8 result kind", 32'(res_kind), 1);
      chk("R8 final addr", res_value, word);
      chk("R8 busy low", 32'(busy), 0);
      chk("R13 no wb", 32'(wb_en), 0);
      @(posedge clk);
      @(negedge clk);
      chk("R9 ignored req", 32'(res_valid), 0);
      chk("R9 no second read", 32'(mem_rd_valid), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_value_modes();
      t_plain_addr();
      t_scaled();
      t_auto();
      t_wrap();
      t_illegal();
      t_indirect(0, 32'h0000_4000, 32'h0001_2340);
      t_indirect(4, 32'hFFFF_FF00, 32'hCAFE_F00C);
      issue(4'd0, 2'd0, 2'd0, 32'h0000_0ABC, 0, 0);
      expect_res("R2 after indirect", 2'd0, 32'h0000_0ABC, 1'b0, 0);
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule